// File: doc/BRIEF.md
# Z80 I/O Cycle Capture Bridge

This block lets a slow service processor stand in for port-mapped peripherals on a Z80-style bus. It watches the active-low IORQ, RD, WR and M1 strobes, sorts each bus cycle into I/O read, I/O write or interrupt acknowledge, and ignores all other cycles. When it recognises a cycle, it latches the low address byte and, for a write, the data byte. It then raises a pending flag and pulls WAIT low, so the CPU stalls until the service side has dealt with the access.

The service processor polls a small register port. It reads the status register to see what kind of access is pending. It reads the captured port number and write data. For a read or an acknowledge, it posts the byte the CPU should receive. Then it writes the status register to complete the transaction. That write releases WAIT and clears the status, and the next cycle is caught only on a fresh asserting edge of the strobes.

Top module: `z80_io_bridge`

## Requirements
- R1: After reset, wait_no is high, data_oe_o is low and the status, port and write-data registers read as zero.
- R2: IORQ low with RD low and M1 high is an I/O read. It sets status bit 0 (pending) and bit 1 (read), and drives wait_no low.
- R3: IORQ low with WR low and M1 high is an I/O write. It sets status bits 0 and 2, and stores data_i, which reads back at service address 2.
- R4: The address byte present when the cycle is recognised reads back at service address 1.
- R5: IORQ low with M1 low is an interrupt acknowledge. It sets status bits 0 and 3 only. At most one of bits 1 to 3 is ever set, and bit 0 is set exactly when one of them is.
- R6: M1 low with RD low while IORQ stays high is an opcode fetch. Status stays zero and wait_no stays high.
- R7: While an access is pending, wait_no stays low until the service side writes address 0. That write clears the status and releases wait_no on the next clock. Writing address 0 with nothing pending has no effect.
- R8: A single bus cycle produces exactly one pending event. The status stays zero after completion even while the strobes remain asserted.
- R9: data_o carries the read-data register. data_oe_o is high only while IORQ and RD are low with M1 high, or while IORQ and M1 are low, and it follows those pins combinationally.
- R10: The service side writes the read-data register at address 3, and reads it back at the same address.
- R11: The strobes pass through a two-flop synchroniser. When they change just before a rising edge, wait_no is still high after the second rising edge and falls after the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| iorq_ni | input | 1 | Bus I/O request, active low |
| rd_ni | input | 1 | Bus read strobe, active low |
| wr_ni | input | 1 | Bus write strobe, active low |
| m1_ni | input | 1 | Bus machine-cycle-one strobe, active low |
| addr_i | input | 8 | Low address byte from the bus |
| data_i | input | 8 | Bus data from the CPU |
| data_o | output | 8 | Data returned to the CPU |
| data_oe_o | output | 1 | Enables data_o onto the bus |
| wait_no | output | 1 | Wait request to the CPU, active low |
| svc_we_i | input | 1 | Service-side write enable |
| svc_addr_i | input | 2 | Service register address: 0 status/done, 1 port, 2 write data, 3 read data |
| svc_wdata_i | input | 8 | Service write data |
| svc_rdata_o | output | 8 | Service read data, combinational from svc_addr_i |

## Verification
The assertions assume that the CPU holds its strobes until WAIT is released and for at least three clocks after they first assert. They also assume that the address and write data are stable by the time the synchronised strobes are seen. The bench drives every bus cycle on a falling edge and keeps the strobes low until after the done write. It releases the strobes to idle between cycles, so every cycle begins from a clean deasserted state. Random cycle kinds, addresses and data are drawn with a fixed seed, and opcode fetches are mixed in to exercise the rejection path.

// File: rtl/z80_io_bridge_pkg.sv
package z80_io_bridge_pkg;
  typedef enum logic [1:0] {
    CYC_NONE  = 2'd0,
    CYC_IO_RD = 2'd1,
    CYC_IO_WR = 2'd2,
    CYC_INTA  = 2'd3
  } cyc_kind_e;

  localparam logic [1:0] REG_STATUS = 2'd0;
  localparam logic [1:0] REG_PORT   = 2'd1;
  localparam logic [1:0] REG_WDATA  = 2'd2;
  localparam logic [1:0] REG_RDATA  = 2'd3;

  localparam int ST_PEND = 0;
  localparam int ST_RD   = 1;
  localparam int ST_WR   = 2;
  localparam int ST_INTA = 3;
  localparam int ST_W    = 4;
endpackage

// File: rtl/z80_strobe_sync.sv
module z80_strobe_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] src;
    if (s == 0) begin : g_first
      assign src = async_i;
    end else begin : g_next
      assign src = stage_q[s-1];
    end
    // strobes idle high
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '1;
      else         stage_q[s] <= src;
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/z80_cycle_decode.sv
module z80_cycle_decode
  import z80_io_bridge_pkg::*;
(
  input  logic      iorq_ni,
  input  logic      rd_ni,
  input  logic      wr_ni,
  input  logic      m1_ni,
  output cyc_kind_e kind_o
);
  always_comb begin
    kind_o = CYC_NONE;
    if (!iorq_ni) begin
      if (!m1_ni)      kind_o = CYC_INTA;
      else if (!rd_ni) kind_o = CYC_IO_RD;
      else if (!wr_ni) kind_o = CYC_IO_WR;
    end
  end
endmodule

// File: rtl/z80_io_capture.sv
module z80_io_capture
  import z80_io_bridge_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cyc_kind_e         kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              done_i,
  output logic              pend_o,
  output cyc_kind_e         kind_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  cyc_kind_e         prev_q, kind_q;
  logic              pend_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              detect;

  // asserting edge only, one event per bus cycle
  assign detect = (kind_i != CYC_NONE) && (prev_q == CYC_NONE) && !pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= CYC_NONE;
      kind_q <= CYC_NONE;
      pend_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      prev_q <= kind_i;
      if (detect) begin
        pend_q <= 1'b1;
        kind_q <= kind_i;
        addr_q <= addr_i;
        if (kind_i == CYC_IO_WR) data_q <= data_i;
      end else if (done_i && pend_q) begin
        pend_q <= 1'b0;
        kind_q <= CYC_NONE;
      end
    end
  end

  assign pend_o = pend_q;
  assign kind_o = kind_q;
  assign addr_o = addr_q;
  assign data_o = data_q;
endmodule

// File: rtl/z80_svc_regs.sv
module z80_svc_regs
  import z80_io_bridge_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ST_W-1:0]   status_i,
  input  logic [ADDR_W-1:0] port_i,
  input  logic [DATA_W-1:0] cap_data_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] rd_reg_o,
  output logic              done_o
);
  logic [DATA_W-1:0] rd_reg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           rd_reg_q <= '0;
    else if (we_i && addr_i == REG_RDATA)  rd_reg_q <= wdata_i;
  end

  always_comb begin
    unique case (addr_i)
      REG_STATUS: rdata_o = DATA_W'(status_i);
      REG_PORT:   rdata_o = DATA_W'(port_i);
      REG_WDATA:  rdata_o = cap_data_i;
      default:    rdata_o = rd_reg_q;
    endcase
  end

  assign done_o   = we_i && (addr_i == REG_STATUS);
  assign rd_reg_o = rd_reg_q;
endmodule

// File: rtl/z80_io_bridge.sv
module z80_io_bridge
  import z80_io_bridge_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              iorq_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic              m1_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              wait_no,
  input  logic              svc_we_i,
  input  logic [1:0]        svc_addr_i,
  input  logic [DATA_W-1:0] svc_wdata_i,
  output logic [DATA_W-1:0] svc_rdata_o
);
  localparam int NSTB = 4;

  logic [NSTB-1:0]   stb_sync;
  cyc_kind_e         kind_sync, kind_raw, kind_cap;
  logic              pend, done;
  logic [ADDR_W-1:0] port_q;
  logic [DATA_W-1:0] wdata_q;
  logic [ST_W-1:0]   status;

  z80_strobe_sync #(.WIDTH(NSTB), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({m1_ni, wr_ni, rd_ni, iorq_ni}),
    .sync_o (stb_sync)
  );

  z80_cycle_decode u_dec_sync (
    .iorq_ni(stb_sync[0]),
    .rd_ni  (stb_sync[1]),
    .wr_ni  (stb_sync[2]),
    .m1_ni  (stb_sync[3]),
    .kind_o (kind_sync)
  );

  // raw-pin decode gates the bus driver without sync latency
  z80_cycle_decode u_dec_raw (
    .iorq_ni(iorq_ni),
    .rd_ni  (rd_ni),
    .wr_ni  (wr_ni),
    .m1_ni  (m1_ni),
    .kind_o (kind_raw)
  );

  z80_io_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .kind_i(kind_sync),
    .addr_i(addr_i),
    .data_i(data_i),
    .done_i(done),
    .pend_o(pend),
    .kind_o(kind_cap),
    .addr_o(port_q),
    .data_o(wdata_q)
  );

  always_comb begin
    status          = '0;
    status[ST_PEND] = pend;
    status[ST_RD]   = (kind_cap == CYC_IO_RD);
    status[ST_WR]   = (kind_cap == CYC_IO_WR);
    status[ST_INTA] = (kind_cap == CYC_INTA);
  end

  z80_svc_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_svc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (svc_we_i),
    .addr_i    (svc_addr_i),
    .wdata_i   (svc_wdata_i),
    .status_i  (status),
    .port_i    (port_q),
    .cap_data_i(wdata_q),
    .rdata_o   (svc_rdata_o),
    .rd_reg_o  (data_o),
    .done_o    (done)
  );

  assign data_oe_o = (kind_raw == CYC_IO_RD) || (kind_raw == CYC_INTA);
  assign wait_no   = !pend;
endmodule

// File: rtl/z80_io_bridge_chk.sv
module z80_io_bridge_chk
  import z80_io_bridge_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            iorq_ni,
  input logic            data_oe_o,
  input logic            wait_no,
  input logic            svc_we_i,
  input logic [1:0]      svc_addr_i,
  input logic [ST_W-1:0] status
);
  logic done_wr;
  assign done_wr = svc_we_i && (svc_addr_i == REG_STATUS);

  AST_WAIT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wait_no && !done_wr) |=> !wait_no); // R7
  AST_DONE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wait_no && done_wr) |=> (wait_no && status == '0)); // R7
  AST_KIND_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(status[ST_INTA:ST_RD]) && (status[ST_PEND] == |status[ST_INTA:ST_RD])); // R5
  AST_OE_NEEDS_IORQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> !iorq_ni); // R9
  AST_IORQ_BEFORE_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wait_no) |-> $past(!iorq_ni, 3)); // R6
  AST_WAIT_IS_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_no == !status[ST_PEND]); // R2
endmodule

bind z80_io_bridge z80_io_bridge_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .iorq_ni   (iorq_ni),
  .data_oe_o (data_oe_o),
  .wait_no   (wait_no),
  .svc_we_i  (svc_we_i),
  .svc_addr_i(svc_addr_i),
  .status    (status)
);

// File: tb/z80_io_bridge_test.sv
`timescale 1ns/1ps
module z80_io_bridge_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, m1_n = 1'b1;
  logic [7:0] addr = '0, dbus = '0;
  logic [7:0] data_o, svc_rdata;
  logic       data_oe, wait_n;
  logic       svc_we = 1'b0;
  logic [1:0] svc_addr = '0;
  logic [7:0] svc_wdata = '0;
  int checks = 0, fails = 0;

  localparam int K_RD = 0, K_WR = 1, K_INTA = 2, K_FETCH = 3;

  always #4 clk = ~clk;

  z80_io_bridge uut (
    .clk_i(clk), .rst_ni(rst_n),
    .iorq_ni(iorq_n), .rd_ni(rd_n), .wr_ni(wr_n), .m1_ni(m1_n),
    .addr_i(addr), .data_i(dbus), .data_o(data_o), .data_oe_o(data_oe),
    .wait_no(wait_n), .svc_we_i(svc_we), .svc_addr_i(svc_addr),
    .svc_wdata_i(svc_wdata), .svc_rdata_o(svc_rdata)
  );

  function automatic logic [7:0] exp_status(int k);
    case (k)
      K_RD:    return 8'h03;
      K_WR:    return 8'h05;
      K_INTA:  return 8'h09;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic exp_oe(int k);
    return (k == K_RD) || (k == K_INTA);
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic svc_read(logic [1:0] a, output logic [7:0] v);
    svc_addr = a;
    #1 v = svc_rdata;
  endtask

  task automatic svc_write(logic [1:0] a, logic [7:0] v);
    @(negedge clk);
    svc_addr = a; svc_wdata = v; svc_we = 1'b1;
    @(negedge clk);
    svc_we = 1'b0;
  endtask

  task automatic drive_kind(int k);
    iorq_n = !(k != K_FETCH);
    m1_n   = !(k == K_INTA || k == K_FETCH);
    rd_n   = !(k == K_RD || k == K_FETCH);
    wr_n   = !(k == K_WR);
  endtask

  task automatic idle_bus();
    @(negedge clk);
    iorq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; m1_n = 1'b1;
    #1 chk("R9 oe idle", {7'd0, data_oe}, 8'h00);
    repeat (2) @(negedge clk);
  endtask

  task automatic bus_cycle(int k, logic [7:0] a, logic [7:0] d, logic [7:0] rv, bit timing);
    logic [7:0] v;
    @(negedge clk);
    addr = a; dbus = d;
    drive_kind(k);
    #1 chk("R9 oe follows pins", {7'd0, data_oe}, {7'd0, exp_oe(k)});
    repeat (2) @(posedge clk);
    #1 if (timing) chk("R11 wait high after two edges", {7'd0, wait_n}, 8'h01);
    @(posedge clk);
    #1 if (timing) chk("R11 wait low after third edge", {7'd0, wait_n}, {7'd0, k == K_FETCH});
    @(negedge clk);
    svc_read(2'd0, v);
    chk(k == K_FETCH ? "R6 fetch status" : "R2/R3/R5 status", v, exp_status(k));
    chk(k == K_FETCH ? "R6 fetch wait" : "R2 wait", {7'd0, wait_n}, {7'd0, k == K_FETCH});
    if (k != K_FETCH) begin
      svc_read(2'd1, v);
      chk("R4 port byte", v, a);
      if (k == K_WR) begin
        svc_read(2'd2, v);
        chk("R3 write data", v, d);
      end
      svc_write(2'd3, rv);
      svc_read(2'd3, v);
      chk("R10 rdata readback", v, rv);
      if (exp_oe(k)) chk("R9 data_o", data_o, rv);
      repeat (3) @(negedge clk);
      chk("R7 wait held", {7'd0, wait_n}, 8'h00);
      svc_write(2'd0, 8'hA5);
      chk("R7 wait released", {7'd0, wait_n}, 8'h01);
      repeat (4) @(negedge clk);
      svc_read(2'd0, v);
      chk("R8 no second event", v, 8'h00);
      chk("R8 wait stays high", {7'd0, wait_n}, 8'h01);
      chk("R9 oe held with strobes", {7'd0, data_oe}, {7'd0, exp_oe(k)});
    end
    idle_bus();
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd20241));
    repeat (3) @(negedge clk);
    chk("R1 wait reset", {7'd0, wait_n}, 8'h01);
    chk("R1 oe reset", {7'd0, data_oe}, 8'h00);
    svc_read(2'd0, v); chk("R1 status reset", v, 8'h00);
    svc_read(2'd1, v); chk("R1 port reset", v, 8'h00);
    svc_read(2'd2, v); chk("R1 wdata reset", v, 8'h00);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    svc_write(2'd0, 8'h00);
    svc_read(2'd0, v); chk("R7 done while idle", v, 8'h00);
    chk("R7 done while idle wait", {7'd0, wait_n}, 8'h01);

    bus_cycle(K_RD, 8'h80, 8'h00, 8'h5A, 1'b1);
    bus_cycle(K_WR, 8'h00, 8'hFF, 8'h00, 1'b1);
    bus_cycle(K_INTA, 8'hFF, 8'h00, 8'h60, 1'b1);
    bus_cycle(K_FETCH, 8'h12, 8'h34, 8'h00, 1'b1);

    for (int i = 0; i < 60; i++) begin
      int k;
      k = int'($urandom_range(3, 0));
      bus_cycle(k, 8'($urandom), 8'($urandom), 8'($urandom), 1'b0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule